// File: doc/BRIEF.md
# STM-1 Frame Alignment Unit

This block sits behind a byte aligner on an STM-1 receive path. It takes one byte per clock, qualified by a valid strobe. It hunts for the frame alignment word, which is three bytes of 0xF6 followed by three bytes of 0x28. Once it has confirmed where frames begin, it stamps every byte with its row and column inside the 9 x 270 frame. It also marks the first byte of each frame and the nine overhead columns of every row.

The block watches the alignment word once per frame for as long as it stays locked. When the word goes missing for five frames in a row, it reports out-of-frame and starts hunting again. If out-of-frame lasts 24 frames (3 ms at 8000 frames per second), it raises loss-of-frame. Loss-of-frame asks downstream logic for an alarm indication signal, and while it is raised the block replaces every byte it passes on with all ones. Loss-of-frame drops again after 24 frames spent continuously in frame.

Top module: `stm1_framer`

## Requirements
- R1: After reset, `oof` is 1, and `lof`, `ais_req`, `out_valid`, `frame_start` and `oh_col` are 0.
- R2: Out of lock, every byte position is searched for the alignment word. The word is three 0xF6 bytes followed by three 0x28 bytes, each on a valid byte. A first match is held for confirmation. A second match exactly one frame (2430 valid bytes) later puts the block in frame, and `oof` goes to 0 at that point.
- R3: If the word is absent at the confirmation position, the block goes back to searching and `oof` stays 1.
- R4: Each valid byte leaves the block one cycle later on `out_byte`, with `out_row` (0..8) and `out_col` (0..269) alongside. Positions advance in row-major order, one step per valid byte. The byte after the last 0x28 of an accepted match is row 0, column 6.
- R5: `frame_start` pulses with the byte at row 0, column 0, and `oh_col` is 1 for bytes in columns 0..8. Both are driven only while the block is in frame.
- R6: While the block is in frame, an alignment word found anywhere other than the expected position does not move the row and column count.
- R7: While in frame, four or fewer consecutive missed words keep `oof` at 0. A word found at the expected position clears the miss count.
- R8: The fifth consecutive missed word sets `oof` to 1 on that byte, and searching restarts.
- R9: `lof` rises once `oof` has stayed 1 for 24 x 2430 valid bytes, and `ais_req` equals `lof`.
- R10: While `lof` is 1, every byte on `out_byte` is 0xFF.
- R11: `lof` falls once `oof` has stayed 0 for 24 x 2430 valid bytes.
- R12: A byte with `in_valid` at 0 advances nothing. The cycle after it has `out_valid`, `frame_start` and `oh_col` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte qualifier |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | Output byte qualifier |
| out_byte | output | 8 | Byte passed on, all ones under loss-of-frame |
| out_row | output | 4 | Row index of the output byte, 0..8 |
| out_col | output | 9 | Column index of the output byte, 0..269 |
| frame_start | output | 1 | Pulse with row 0, column 0 while in frame |
| oh_col | output | 1 | Output byte is in overhead columns 0..8 while in frame |
| oof | output | 1 | Out-of-frame |
| lof | output | 1 | Loss-of-frame |
| ais_req | output | 1 | Downstream AIS request |

## Verification
The bench first feeds random noise, which must never produce lock. It then starts clean frames at an arbitrary phase. This shows whether the search really looks at every byte position and whether the first index is placed correctly. A corrupted confirmation frame separates the two-step acquisition from single-match locking. A payload that carries a copy of the alignment word shows whether the block ignores words found away from the expected position once locked. Runs of four misses split by a good frame, followed by five misses, check that the miss count is cleared and that the threshold is exact. Long runs of bad and then good frames place the loss-of-frame edges at the 24-frame boundaries.

// File: rtl/stm1_framer.sv
module stm1_framer #(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int OH_COLS = 9,
  parameter int RUN = 3,
  parameter logic [7:0] A1 = 8'hF6,
  parameter logic [7:0] A2 = 8'h28,
  parameter int MISS_LIMIT = 5,
  parameter int LOF_FRAMES = 24,
  parameter int CLR_FRAMES = 24,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output logic          frame_start,
  output logic          oh_col,
  output logic          oof,
  output logic          lof,
  output logic          ais_req
);
  localparam int PL = 2 * RUN;
  localparam int FB = ROWS * COLS;
  localparam int TW = $clog2(FB);
  localparam int DL = (LOF_FRAMES > CLR_FRAMES) ? LOF_FRAMES : CLR_FRAMES;
  localparam int DW = $clog2(DL + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam logic [8*PL-1:0] PAT = {{RUN{A1}}, {RUN{A2}}};

  typedef enum logic [1:0] {HUNT, CHECK, LOCK} st_t;

  st_t st, st_n;
  logic [8*(PL-1)-1:0] hist;
  logic [8*PL-1:0] window;
  logic [RW-1:0] row_q, row_nx;
  logic [CW-1:0] col_q, col_nx;
  logic [MW-1:0] miss, miss_n;
  logic [TW-1:0] tick;
  logic [DW-1:0] dwell;
  logic hit, at_exp, oof_n;

  assign window  = {hist, in_byte};
  assign hit     = in_valid && (window == PAT);
  assign at_exp  = in_valid && (row_q == '0) && (col_q == CW'(PL - 1));
  assign oof     = (st != LOCK);
  assign oof_n   = (st_n != LOCK);
  assign ais_req = lof;

  always_comb begin
    col_nx = col_q + 1'b1;
    row_nx = row_q;
    if (col_q == CW'(COLS - 1)) begin
      col_nx = '0;
      row_nx = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
    end
  end

  always_comb begin
    st_n   = st;
    miss_n = miss;
    case (st)
      HUNT:  if (hit) st_n = CHECK;
      CHECK: if (at_exp) st_n = hit ? LOCK : HUNT;
      LOCK:  if (at_exp) begin
               if (hit) miss_n = '0;
               else if (miss == MW'(MISS_LIMIT - 1)) begin
                 st_n   = HUNT;
                 miss_n = '0;
               end else miss_n = miss + 1'b1;
             end
      default: st_n = HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HUNT;
      miss <= '0;
      hist <= '0;
      row_q <= '0;
      col_q <= '0;
      tick <= '0;
      dwell <= '0;
      lof <= 1'b0;
      out_valid <= 1'b0;
      out_byte <= '0;
      out_row <= '0;
      out_col <= '0;
      frame_start <= 1'b0;
      oh_col <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      frame_start <= in_valid && !oof && row_q == '0 && col_q == '0;
      oh_col      <= in_valid && !oof && col_q < CW'(OH_COLS);
      if (in_valid) begin
        out_byte <= lof ? 8'hFF : in_byte;
        out_row  <= row_q;
        out_col  <= col_q;
        hist     <= window[8*(PL-1)-1:0];
        st       <= st_n;
        miss     <= miss_n;
        if (st == HUNT && hit) begin
          row_q <= '0;
          col_q <= CW'(PL);
        end else begin
          row_q <= row_nx;
          col_q <= col_nx;
        end
        if (oof_n != oof) begin
          tick  <= '0;
          dwell <= '0;
        end else if (tick == TW'(FB - 1)) begin
          tick <= '0;
          if (dwell != DW'(DL)) dwell <= dwell + 1'b1;
          if (oof && dwell == DW'(LOF_FRAMES - 1)) lof <= 1'b1;
          if (!oof && dwell == DW'(CLR_FRAMES - 1)) lof <= 1'b0;
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stm1_framer_chk.sv
module stm1_framer_chk #(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int OH_COLS = 9,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [7:0]    out_byte,
  input logic [RW-1:0] out_row,
  input logic [CW-1:0] out_col,
  input logic          frame_start,
  input logic          oh_col,
  input logic          oof,
  input logic          lof
);
  AST_FS_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (out_row == '0 && out_col == '0)) else $error("frame_start off origin"); // R5
  AST_OH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    oh_col |-> out_col < CW'(OH_COLS)) else $error("oh_col outside overhead"); // R5
  AST_MARK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start || oh_col) |-> $past(!oof)) else $error("marker while out of frame"); // R5
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_row < RW'(ROWS) && out_col < CW'(COLS))) else $error("index out of range"); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!frame_start && !oh_col)) else $error("marker on idle cycle"); // R12
  AST_LOF_FROM_OOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> oof) else $error("lof rose while in frame"); // R9
  AST_LOF_CLEAR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof) |-> !oof) else $error("lof fell while out of frame"); // R11
  AST_AIS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lof) |=> out_byte == 8'hFF) else $error("byte not all ones under lof"); // R10
endmodule

bind stm1_framer stm1_framer_chk #(.ROWS(ROWS), .COLS(COLS), .OH_COLS(OH_COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_byte(out_byte), .out_row(out_row), .out_col(out_col),
  .frame_start(frame_start), .oh_col(oh_col), .oof(oof), .lof(lof)
);

// File: tb/stm1_framer_bench.sv
module stm1_framer_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [7:0] in_byte;
  logic out_valid, frame_start, oh_col, oof, lof, ais_req;
  logic [7:0] out_byte;
  logic [3:0] out_row;
  logic [8:0] out_col;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  stm1_framer u_stm1_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_row(out_row), .out_col(out_col),
    .frame_start(frame_start), .oh_col(oh_col), .oof(oof), .lof(lof), .ais_req(ais_req)
  );

  // Reference state derived from the requirements (frame 2430 bytes, word F6 F6 F6 28 28 28).
  int m_st = 0;
  int m_row = 0, m_col = 0, m_miss = 0, m_tick = 0, m_dwell = 0;
  bit m_lof = 0;
  int hist[6] = '{default: 0};
  int e_valid = 0, e_byte = 0, e_row = 0, e_col = 0, e_fs = 0, e_oh = 0, e_oof = 1, e_lof = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(bit v, int b);
    bit hit, at, locked, nlocked;
    int nst;
    locked = (m_st == 2);
    e_valid = v;
    e_fs = v && locked && m_row == 0 && m_col == 0;
    e_oh = v && locked && m_col < 9;
    if (!v) return;
    e_byte = m_lof ? 255 : b;
    e_row = m_row;
    e_col = m_col;
    for (int i = 0; i < 5; i++) hist[i] = hist[i+1];
    hist[5] = b;
    hit = hist[0] == 8'hF6 && hist[1] == 8'hF6 && hist[2] == 8'hF6 &&
          hist[3] == 8'h28 && hist[4] == 8'h28 && hist[5] == 8'h28;
    at = (m_row == 0 && m_col == 5);
    nst = m_st;
    if (m_st == 0 && hit) nst = 1;
    else if (m_st == 1 && at) nst = hit ? 2 : 0;
    else if (m_st == 2 && at) begin
      if (hit) m_miss = 0;
      else if (m_miss == 4) begin nst = 0; m_miss = 0; end
      else m_miss++;
    end
    if (m_st == 0 && hit) begin m_row = 0; m_col = 6; end
    else begin
      m_col++;
      if (m_col == 270) begin m_col = 0; m_row = (m_row + 1) % 9; end
    end
    nlocked = (nst == 2);
    if (nlocked != locked) begin m_tick = 0; m_dwell = 0; end
    else if (m_tick == 2429) begin
      m_tick = 0;
      m_dwell++;
      if (!locked && m_dwell == 24) m_lof = 1;
      if (locked && m_dwell == 24) m_lof = 0;
    end else m_tick++;
    m_st = nst;
    e_oof = !nlocked;
    e_lof = m_lof;
  endtask

  task automatic push(bit v, logic [7:0] b);
    @(negedge clk);
    in_valid = v;
    in_byte = b;
    model(v, int'(b));
    @(posedge clk);
    #1;
    chk("R12", out_valid, e_valid);
    chk("R5", frame_start, e_fs);
    chk("R5", oh_col, e_oh);
    if (e_valid) begin
      chk("R4", out_row, e_row);
      chk("R4", out_col, e_col);
      chk("R10", out_byte, e_byte);
    end
    chk("R8", oof, e_oof);
    chk("R9", lof, e_lof);
    chk("R9", ais_req, e_lof);
  endtask

  // kind: 0 good, 1 word broken, 2 good with a copy of the word in payload
  task automatic send_frame(int kind, bit gaps);
    for (int p = 0; p < 2430; p++) begin
      logic [7:0] b;
      b = 8'($urandom());
      if (p < 3) b = (kind == 1 && p == 0) ? 8'h00 : 8'hF6;
      else if (p < 6) b = 8'h28;
      else if (kind == 2 && p >= 1200 && p < 1203) b = 8'hF6;
      else if (kind == 2 && p >= 1203 && p < 1206) b = 8'h28;
      if (gaps && (p % 97) == 50) push(1'b0, 8'h00);
      push(1'b1, b);
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_byte = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", oof, 1);
    chk("R1", lof, 0);
    chk("R1", ais_req, 0);
    chk("R1", out_valid, 0);
    chk("R1", frame_start, 0);
    chk("R1", oh_col, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 1000; i++) push(1'b1, 8'($urandom()));
    chk("R2", oof, 1);
    for (int p = 1500; p < 2430; p++) push(1'b1, 8'($urandom()));

    send_frame(0, 1'b1);
    chk("R2", oof, 1);
    send_frame(1, 1'b1);
    chk("R3", oof, 1);
    send_frame(0, 1'b1);
    send_frame(0, 1'b1);
    chk("R2", oof, 0);
    send_frame(2, 1'b1);
    chk("R6", oof, 0);
    chk("R6", out_row, 8);
    chk("R6", out_col, 269);

    for (int f = 0; f < 4; f++) send_frame(1, 1'b0);
    chk("R7", oof, 0);
    send_frame(0, 1'b0);
    for (int f = 0; f < 4; f++) send_frame(1, 1'b0);
    chk("R7", oof, 0);
    send_frame(1, 1'b0);
    chk("R8", oof, 1);

    for (int f = 0; f < 23; f++) send_frame(1, 1'b0);
    chk("R9", lof, 0);
    send_frame(1, 1'b0);
    chk("R9", lof, 1);
    chk("R9", ais_req, 1);
    chk("R10", out_byte, 255);

    for (int f = 0; f < 25; f++) send_frame(0, 1'b0);
    chk("R11", oof, 0);
    chk("R11", lof, 1);
    send_frame(0, 1'b0);
    send_frame(0, 1'b0);
    chk("R11", lof, 0);
    chk("R11", ais_req, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule